// File: doc/BRIEF.md
# Descriptor Ring Consumer with Generation Check

This block owns the read side of a descriptor ring kept in word-addressed memory. A producer elsewhere fills fixed-size entries and moves a head pointer forward. The consumer keeps its own read position (the tail), a cached copy of the head, and the generation value it expects to find in the next fresh entry. Each entry carries a small generation stamp in its final word, and the producer bumps the stamp every time it wraps. An entry counts as new only when its stamp matches the consumer's expected generation, so stale entries left over from an earlier lap are never mistaken for fresh ones.

The block takes one command at a time. Peek and get-next fetch the stamp word of the entry at the tail. Peek reports the entry without consuming it. Get-next also moves the tail forward by one entry and wraps at the ring end. The ring length in words may be any multiple of the entry length, so it need not be a power of two. A count command returns how many entries lie between the tail and the head. It may first refresh the cached head from the live head input, and it divides the word distance by the entry size with a small iterative subtractor. A publish command copies the tail into an output register that the producer watches.

Top module: `ring_consumer`

## Requirements
- R1: After synchronous reset the tail, the cached head and `tail_out` are 0, the expected generation is 1, and `busy`, `rsp_valid` and `mem_rd_en` are low.
- R2: Peek (cmd_op 0) and get-next (cmd_op 1) read word `tail + ENTRY_WORDS - 1`. When bits [LC_LSB+LC_W-1:LC_LSB] of that word differ from the expected generation, the response has `rsp_hit` low, and neither the tail nor the generation changes.
- R3: A get-next that hits returns `rsp_addr` equal to the old tail and moves the tail to (tail + ENTRY_WORDS) mod RING_WORDS.
- R4: When a get-next moves the tail to 0, the expected generation increments modulo 2^LC_W (15 wraps to 0). Otherwise it stays the same.
- R5: A peek that hits returns the tail as `rsp_addr` and changes neither the tail nor the generation, so a following get-next returns the same address.
- R6: Count (cmd_op 2) returns (head - tail)/ENTRY_WORDS when head >= tail, else (RING_WORDS - tail + head)/ENTRY_WORDS, on `rsp_count`.
- R7: With `cmd_sync` high, count first loads `hw_head` into the cached head and uses it. With `cmd_sync` low, it uses the cached head as it stands.
- R8: Publish (cmd_op 3) copies the tail into `tail_out` and gives a response one cycle after acceptance. `tail_out` changes at no other time.
- R9: A command is accepted only while `busy` is low. Peek and get-next answer two cycles after acceptance, with `busy` high in between. A command presented while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_op | input | 2 | 0 peek, 1 get-next, 2 count, 3 publish |
| cmd_sync | input | 1 | Count only: refresh cached head from hw_head |
| hw_head | input | ADDR_W | Producer head pointer in words |
| mem_rd_en | output | 1 | Ring memory read request |
| mem_rd_addr | output | ADDR_W | Word address of the stamp word |
| mem_rd_data | input | DATA_W | Read data, one cycle after mem_rd_en |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_op | output | 2 | Operation being answered |
| rsp_hit | output | 1 | Peek/get-next found a fresh entry |
| rsp_addr | output | ADDR_W | Entry start word for peek/get-next |
| rsp_count | output | ADDR_W+1 | Entry count for count |
| tail_out | output | ADDR_W | Published tail pointer |

## Verification
A corrupted tail shows up at the next peek or get-next as a wrong `rsp_addr`, and it shows up on `tail_out` after the next publish. A wrong expected generation stays hidden until the first entry read after a wrap. From that point every get-next misses, or a stale entry hits, so long runs drive the producer through more than sixteen laps. A stale cached head appears only in unsynced counts, so the bench mixes synced and unsynced counts after the producer has moved.

// File: rtl/ring_consumer_pkg.sv
package ring_consumer_pkg;

    typedef enum logic [1:0] {
        OP_PEEK    = 2'd0,
        OP_GET     = 2'd1,
        OP_COUNT   = 2'd2,
        OP_PUBLISH = 2'd3
    } ring_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE  = 2'd1,
        ST_DIVIDE = 2'd2
    } ring_state_e;

    // advance a word pointer by one step, folding at the ring length
    function automatic logic [15:0] ring_wrap_add(input logic [15:0] cur,
                                                  input logic [15:0] step,
                                                  input logic [15:0] size);
        logic [16:0] sum;
        sum = {1'b0, cur} + {1'b0, step};
        if (sum >= {1'b0, size})
            sum = sum - {1'b0, size};
        return sum[15:0];
    endfunction

    // word distance from consumer position to producer position
    function automatic logic [15:0] ring_distance(input logic [15:0] head,
                                                  input logic [15:0] tail,
                                                  input logic [15:0] size);
        if (head >= tail)
            return head - tail;
        return size - tail + head;
    endfunction

endpackage

// File: rtl/ring_tail_track.sv
module ring_tail_track
    import ring_consumer_pkg::*;
#(
    parameter int RING_WORDS  = 60,
    parameter int ENTRY_WORDS = 3,
    parameter int ADDR_W      = 6,
    parameter int LC_W        = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [ADDR_W-1:0] tail,
    output logic [LC_W-1:0]   exp_lc,
    output logic [ADDR_W-1:0] stamp_addr
);

    logic [ADDR_W-1:0] tail_next;
    logic [LC_W-1:0]   lc_next;

    always_comb begin
        tail_next = ADDR_W'(ring_wrap_add(16'(tail), 16'(ENTRY_WORDS), 16'(RING_WORDS)));
        lc_next   = (tail_next == '0) ? LC_W'(exp_lc + 1'b1) : exp_lc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tail   <= '0;
            exp_lc <= LC_W'(1);
        end else if (advance) begin
            tail   <= tail_next;
            exp_lc <= lc_next;
        end
    end

    assign stamp_addr = ADDR_W'(32'(tail) + ENTRY_WORDS - 1);

    // R3
    tail_align_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(tail) < RING_WORDS) && ((32'(tail) % ENTRY_WORDS) == 0));

    // R4
    lc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(advance) && tail == '0) |-> exp_lc == LC_W'($past(exp_lc) + 1'b1));

    // R4
    lc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tail != '0) |-> $stable(exp_lc));

endmodule

// File: rtl/ring_count_div.sv
module ring_count_div #(
    parameter int RING_WORDS  = 60,
    parameter int ENTRY_WORDS = 3,
    parameter int CNT_W       = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] dividend,
    output logic             done,
    output logic [CNT_W-1:0] quotient
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(ENTRY_WORDS);
    localparam int MAX_Q = RING_WORDS / ENTRY_WORDS;

    logic [CNT_W-1:0] remain;
    logic             running;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain   <= '0;
            quotient <= '0;
            running  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                remain   <= dividend;
                quotient <= '0;
                running  <= 1'b1;
            end else if (running) begin
                if (remain >= STEP) begin
                    remain   <= remain - STEP;
                    quotient <= quotient + 1'b1;
                end else begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    // R6
    quot_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(quotient) <= MAX_Q);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(running) && !running);

endmodule

// File: rtl/ring_consumer.sv
module ring_consumer
    import ring_consumer_pkg::*;
#(
    parameter int RING_WORDS  = 60,
    parameter int ENTRY_WORDS = 3,
    parameter int DATA_W      = 32,
    parameter int LC_LSB      = 28,
    parameter int LC_W        = 4,
    parameter int ADDR_W      = $clog2(RING_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_sync,
    input  logic [ADDR_W-1:0] hw_head,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              busy,
    output logic              rsp_valid,
    output logic [1:0]        rsp_op,
    output logic              rsp_hit,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [ADDR_W:0]   rsp_count,
    output logic [ADDR_W-1:0] tail_out
);

    localparam int CNT_W = ADDR_W + 1;

    ring_state_e       state;
    ring_op_e          op_in;
    ring_op_e          op_held;
    logic              accept;
    logic              advance;
    logic              stamp_match;
    logic [ADDR_W-1:0] tail;
    logic [LC_W-1:0]   exp_lc;
    logic [ADDR_W-1:0] stamp_addr;
    logic [ADDR_W-1:0] cached_head;
    logic [ADDR_W-1:0] head_pick;
    logic [CNT_W-1:0]  distance;
    logic              div_start;
    logic              div_done;
    logic [CNT_W-1:0]  div_q;
    logic              unused_data_bits;

    assign op_in  = ring_op_e'(cmd_op);
    assign busy   = (state != ST_IDLE);
    assign accept = cmd_valid && !busy;

    ring_tail_track #(
        .RING_WORDS  (RING_WORDS),
        .ENTRY_WORDS (ENTRY_WORDS),
        .ADDR_W      (ADDR_W),
        .LC_W        (LC_W)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .advance    (advance),
        .tail       (tail),
        .exp_lc     (exp_lc),
        .stamp_addr (stamp_addr)
    );

    always_comb begin
        head_pick = cmd_sync ? hw_head : cached_head;
        distance  = CNT_W'(ring_distance(16'(head_pick), 16'(tail), 16'(RING_WORDS)));
        div_start = accept && (op_in == OP_COUNT);
    end

    ring_count_div #(
        .RING_WORDS  (RING_WORDS),
        .ENTRY_WORDS (ENTRY_WORDS),
        .CNT_W       (CNT_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (distance),
        .done     (div_done),
        .quotient (div_q)
    );

    assign mem_rd_en        = accept && (op_in == OP_PEEK || op_in == OP_GET);
    assign mem_rd_addr      = stamp_addr;
    assign stamp_match      = (mem_rd_data[LC_LSB +: LC_W] == exp_lc);
    assign advance          = (state == ST_PROBE) && stamp_match && (op_held == OP_GET);
    assign unused_data_bits = ^mem_rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            op_held     <= OP_PEEK;
            cached_head <= '0;
            tail_out    <= '0;
            rsp_valid   <= 1'b0;
            rsp_op      <= 2'd0;
            rsp_hit     <= 1'b0;
            rsp_addr    <= '0;
            rsp_count   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_held <= op_in;
                        case (op_in)
                            OP_PEEK, OP_GET: state <= ST_PROBE;
                            OP_COUNT: begin
                                state <= ST_DIVIDE;
                                if (cmd_sync)
                                    cached_head <= hw_head;
                            end
                            default: begin
                                tail_out  <= tail;
                                rsp_valid <= 1'b1;
                                rsp_op    <= OP_PUBLISH;
                                rsp_hit   <= 1'b0;
                            end
                        endcase
                    end
                end
                ST_PROBE: begin
                    rsp_valid <= 1'b1;
                    rsp_op    <= op_held;
                    rsp_hit   <= stamp_match;
                    rsp_addr  <= tail;
                    state     <= ST_IDLE;
                end
                ST_DIVIDE: begin
                    if (div_done) begin
                        rsp_valid <= 1'b1;
                        rsp_op    <= OP_COUNT;
                        rsp_hit   <= 1'b0;
                        rsp_count <= div_q;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5
    peek_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_op == OP_PEEK) |-> $stable(tail) && $stable(exp_lc));

    // R2
    miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit && rsp_op == OP_GET) |-> $stable(tail));

    // R8
    tail_out_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tail_out) |-> $past(accept && op_in == OP_PUBLISH));

    // R9
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid));

endmodule

// File: tb/ring_consumer_test.sv
module ring_consumer_test;

    localparam int R   = 60;
    localparam int E   = 3;
    localparam int AW  = 6;
    localparam int DW  = 32;
    localparam int LCL = 28;
    localparam int NE  = R / E;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic          cmd_sync = 1'b0;
    logic [AW-1:0] hw_head = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [DW-1:0] mem_rd_data = '0;
    logic          busy, rsp_valid, rsp_hit;
    logic [1:0]    rsp_op;
    logic [AW-1:0] rsp_addr, tail_out;
    logic [AW:0]   rsp_count;

    ring_consumer uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sync(cmd_sync), .hw_head(hw_head), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_hit(rsp_hit),
        .rsp_addr(rsp_addr), .rsp_count(rsp_count), .tail_out(tail_out)
    );

    always #5 clk = ~clk;

    logic [DW-1:0] mem [0:R-1];
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    int checks = 0, fails = 0;
    int prod_ptr = 0, prod_lc = 1, occ = 0;
    int m_tail = 0, m_cache = 0, m_tout = 0;
    int lat;
    logic          r_hit;
    logic [AW-1:0] r_addr;
    logic [AW:0]   r_count;
    logic [1:0]    r_op;

    function automatic int exp_count(int h, int t);
        if (h >= t) return (h - t) / E;
        return (R - t + h) / E;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push();
        for (int w = 0; w < E - 1; w++) mem[prod_ptr + w] = $urandom;
        mem[prod_ptr + E - 1] = {prod_lc[3:0], 28'($urandom)};
        prod_ptr = prod_ptr + E;
        if (prod_ptr == R) begin
            prod_ptr = 0;
            prod_lc  = (prod_lc + 1) % 16;
        end
        hw_head = AW'(prod_ptr);
        occ++;
    endtask

    task automatic issue(input logic [1:0] op, input logic s);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_sync = s;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        r_hit = rsp_hit; r_addr = rsp_addr; r_count = rsp_count; r_op = rsp_op;
    endtask

    task automatic do_get(input string req);
        bit exp_hit;
        exp_hit = (occ > 0);
        issue(2'd1, 1'b0);
        chk(r_hit == exp_hit, {req, " get hit"}, int'(r_hit), int'(exp_hit));
        if (exp_hit) begin
            chk(int'(r_addr) == m_tail, {req, " get addr"}, int'(r_addr), m_tail);
            m_tail = (m_tail + E) % R;
            occ--;
        end
    endtask

    task automatic do_peek(input string req);
        bit exp_hit;
        exp_hit = (occ > 0);
        issue(2'd0, 1'b0);
        chk(r_hit == exp_hit, {req, " peek hit"}, int'(r_hit), int'(exp_hit));
        if (exp_hit)
            chk(int'(r_addr) == m_tail, {req, " peek addr"}, int'(r_addr), m_tail);
    endtask

    task automatic do_count(input logic s, input string req);
        if (s) m_cache = prod_ptr;
        issue(2'd2, s);
        chk(int'(r_count) == exp_count(m_cache, m_tail), {req, " count"},
            int'(r_count), exp_count(m_cache, m_tail));
    endtask

    task automatic do_publish(input string req);
        issue(2'd3, 1'b0);
        m_tout = m_tail;
        chk(lat == 1, {req, " publish latency"}, lat, 1);
        chk(int'(tail_out) == m_tout, {req, " tail_out"}, int'(tail_out), m_tout);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0c4a));
        for (int i = 0; i < R; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(mem_rd_en == 1'b0, "R1 mem_rd_en", int'(mem_rd_en), 0);
        chk(tail_out == '0, "R1 tail_out", int'(tail_out), 0);
        do_count(1'b0, "R1");
        // R2 zero memory reads as empty
        do_peek("R2 empty");
        do_get("R2 empty");

        // R2 stale stamp: pointers say one entry, stamp says old lap
        mem[0] = 32'h1; mem[1] = 32'h2; mem[2] = {4'd2, 28'h0};
        hw_head = AW'(3);
        m_cache = 3;
        issue(2'd2, 1'b1);
        chk(int'(r_count) == 1, "R7 sync count", int'(r_count), 1);
        issue(2'd1, 1'b0);
        chk(r_hit == 1'b0, "R2 stale get", int'(r_hit), 0);
        chk(lat == 2, "R9 probe latency", lat, 2);
        mem[2] = {4'd1, 28'h0};
        prod_ptr = 3; occ = 1;
        do_peek("R5 first");
        do_peek("R5 repeat");
        do_get("R3 after peek");
        do_get("R2 drained");

        // R7 stale cache
        push(); push();
        do_count(1'b0, "R7 unsynced");
        do_count(1'b1, "R7 synced");
        do_publish("R8");

        // R9 command while busy is ignored
        do_get("R3");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0;
        @(negedge clk);
        chk(busy == 1'b1, "R9 busy", int'(busy), 1);
        cmd_op = 2'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(int'(tail_out) == m_tout, "R9 ignored publish", int'(tail_out), m_tout);

        // R6 full ring with head behind tail
        while (occ < NE - 1) push();
        do_count(1'b1, "R6 full");
        while (occ > 0) do_get("R3 drain");
        do_count(1'b1, "R6 empty");

        // random mix
        for (int it = 0; it < 800; it++) begin
            int sel;
            sel = $urandom % 8;
            if (sel < 3) begin
                if (occ < NE - 1) push();
            end else if (sel == 3) do_peek("R5 rand");
            else if (sel < 6) do_get("R3 rand");
            else if (sel == 6) do_count(1'(($urandom % 2)), "R6 rand");
            else do_publish("R8 rand");
        end

        // R4 generation wrap over many laps
        for (int it = 0; it < 17 * NE; it++) begin
            push();
            do_get("R4 lap");
        end
        do_get("R4 empty after laps");
        do_publish("R8 final");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule